// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Width Converter

This block joins a long-word side, which carries four 9-bit lanes (36 bits), to a narrow side. The narrow side can run at byte width (one lane), word width (two lanes) or long-word width (all four lanes). It has two independent paths. The unpacker takes one long word from the wide side and sends its slots out on the narrow side one at a time. The packer collects narrow slots and hands the finished long word to the wide side. Every port pair uses a valid/ready handshake. A transfer happens in any cycle in which valid and ready are both high at a rising clock edge.

Two settings are sampled once, at the first clock edge after reset is released: the endian select and the narrow size. They then stay fixed until the next reset. In big-endian order the most significant slot is sent first, and the first slot collected lands in the most significant place. Little-endian order reverses this. At long-word size each word passes through whole, so the endian setting has no effect. Each lane is treated as opaque data.

Top module: `bus_width_conv`

## Requirements
- R1: The endian select (`endian_big_i`, 1 = big) and the size select (`size_sel_i`: 00 byte, 01 word, 10 or 11 long word) are sampled at the first rising clock edge after `rst_n` goes high. Changes to these inputs after that edge have no effect until the next reset.
- R2: While reset is asserted, and until the settings have been sampled, `w2n_wide_ready_o`, `n2w_nar_ready_o`, `w2n_nar_valid_o` and `n2w_wide_valid_o` are all low.
- R3: Unpacker in big-endian byte or word mode: the slots of an accepted long word leave in order from the most significant slot to the least significant.
- R4: Unpacker in little-endian byte or word mode: the slots leave in order from the least significant slot to the most significant.
- R5: Packer in big-endian byte or word mode: the first slot received becomes the most significant slot of the long word, and the last slot received becomes the least significant.
- R6: Packer in little-endian byte or word mode: the first slot received fills the least significant position, and each following slot fills the next position up.
- R7: At long-word size, each long word passes through unchanged in both directions, whatever the endian select.
- R8: A byte slot is bits [8:0] of the narrow data and a word slot is bits [17:0]. Narrow output bits above the slot are zero, and narrow input bits above the slot are ignored.
- R9: `w2n_wide_ready_o` is high only when the unpacker holds no slots, or when its last remaining slot is taken in that same cycle.
- R10: `n2w_wide_valid_o` goes high only after every slot of a long word has been received. While it is high and not accepted, it and `n2w_wide_data_o` hold.
- R11: While `w2n_nar_valid_o` is high and not accepted, it and `w2n_nar_data_o` hold.
- R12: `n2w_nar_ready_o` is high exactly when the settings have been sampled and either no finished long word is waiting or the waiting one is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| endian_big_i | input | 1 | Endian select, 1 = big; sampled after reset release |
| size_sel_i | input | 2 | Narrow size select; sampled after reset release |
| w2n_wide_valid_i | input | 1 | Unpacker long-word input valid |
| w2n_wide_ready_o | output | 1 | Unpacker long-word input ready |
| w2n_wide_data_i | input | 36 | Unpacker long-word input data |
| w2n_nar_valid_o | output | 1 | Unpacker slot output valid |
| w2n_nar_ready_i | input | 1 | Unpacker slot output ready |
| w2n_nar_data_o | output | 36 | Unpacker slot output, right-aligned |
| n2w_nar_valid_i | input | 1 | Packer slot input valid |
| n2w_nar_ready_o | output | 1 | Packer slot input ready |
| n2w_nar_data_i | input | 36 | Packer slot input, right-aligned |
| n2w_wide_valid_o | output | 1 | Packer long-word output valid |
| n2w_wide_ready_i | input | 1 | Packer long-word output ready |
| n2w_wide_data_o | output | 36 | Packer long-word output data |

## Verification
In the unpacker, the last slot of one long word can leave on the same edge at which the next long word is loaded. In the packer, a finished word can be taken by the wide side on the same edge at which the first slot of the following word arrives. The bench makes both coincidences common by toggling valid and ready at random on every side. A queue-based model predicts each ready, valid and data value every cycle, and an extra cycle or a lost slot shows up as a mismatch. The settings inputs are also changed after they have been sampled, to show that the slot order stays as it was latched.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } size_e;

  function automatic size_e decode_size(input logic [1:0] code);
    case (code)
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_WORD;
      default: return SZ_LONG;
    endcase
  endfunction
endpackage

// File: rtl/bwc_cfg_latch.sv
`timescale 1ns/1ps
module bwc_cfg_latch
  import bwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       big_i,
  input  logic [1:0] size_i,
  output logic       ok_o,
  output logic       big_o,
  output size_e      size_o
);
  logic  ok_q, ok_d;
  logic  big_q, big_d;
  size_e size_q, size_d;
  logic  cap_en;

  // capture once, on the first edge after reset release
  assign cap_en = !ok_q;

  always_comb begin
    ok_d   = ok_q;
    big_d  = big_q;
    size_d = size_q;
    if (cap_en) begin
      ok_d   = 1'b1;
      big_d  = big_i;
      size_d = decode_size(size_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      big_q  <= 1'b0;
      size_q <= SZ_LONG;
    end else if (cap_en) begin
      ok_q   <= ok_d;
      big_q  <= big_d;
      size_q <= size_d;
    end
  end

  assign ok_o   = ok_q;
  assign big_o  = big_q;
  assign size_o = size_q;
endmodule

// File: rtl/bwc_lane_map.sv
`timescale 1ns/1ps
module bwc_lane_map
  import bwc_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                               big_i,
  input  size_e                              size_i,
  input  logic [$clog2(LANES)-1:0]           idx_i,
  output logic                               last_o,
  output logic [$clog2(LANE_W*LANES)-1:0]    shift_o,
  output logic [LANE_W*LANES-1:0]            mask_o
);
  localparam int W    = LANE_W * LANES;
  localparam int SH_W = $clog2(W);

  int unsigned slots;
  int unsigned slot_w;
  int unsigned pos;

  always_comb begin
    case (size_i)
      SZ_BYTE: begin slots = LANES;     slot_w = LANE_W;     end
      SZ_WORD: begin slots = LANES / 2; slot_w = 2 * LANE_W; end
      default: begin slots = 1;         slot_w = W;          end
    endcase
    // transfer index -> slot position within the long word
    if (big_i) pos = slots - 1 - int'(idx_i);
    else       pos = int'(idx_i);
    last_o  = (int'(idx_i) == slots - 1);
    shift_o = SH_W'(pos * slot_w);
    mask_o  = {W{1'b1}} >> (W - slot_w);
  end
endmodule

// File: rtl/bwc_unpack.sv
`timescale 1ns/1ps
module bwc_unpack
  import bwc_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_ok_i,
  input  logic                     big_i,
  input  size_e                    size_i,
  input  logic                     wide_valid_i,
  output logic                     wide_ready_o,
  input  logic [LANE_W*LANES-1:0]  wide_data_i,
  output logic                     nar_valid_o,
  input  logic                     nar_ready_i,
  output logic [LANE_W*LANES-1:0]  nar_data_o
);
  localparam int W     = LANE_W * LANES;
  localparam int IDX_W = $clog2(LANES);
  localparam int SH_W  = $clog2(W);

  logic             full_q, full_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     buf_q, buf_d;
  logic             take, load, last, step_en;
  logic [SH_W-1:0]  shift;
  logic [W-1:0]     mask;

  bwc_lane_map #(.LANE_W(LANE_W), .LANES(LANES)) u_map (
    .big_i   (big_i),
    .size_i  (size_i),
    .idx_i   (idx_q),
    .last_o  (last),
    .shift_o (shift),
    .mask_o  (mask)
  );

  assign take         = full_q && nar_ready_i;
  assign wide_ready_o = cfg_ok_i && (!full_q || (take && last));
  assign load         = wide_valid_i && wide_ready_o;
  assign step_en      = take || load;

  always_comb begin
    full_d = full_q;
    idx_d  = idx_q;
    buf_d  = buf_q;
    if (take) begin
      if (last) begin
        full_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d  = idx_q + IDX_W'(1);
      end
    end
    if (load) begin
      full_d = 1'b1;
      idx_d  = '0;
      buf_d  = wide_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      buf_q  <= '0;
    end else if (step_en) begin
      full_q <= full_d;
      idx_q  <= idx_d;
      buf_q  <= buf_d;
    end
  end

  assign nar_valid_o = full_q;
  assign nar_data_o  = (buf_q >> shift) & mask;
endmodule

// File: rtl/bwc_pack.sv
`timescale 1ns/1ps
module bwc_pack
  import bwc_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_ok_i,
  input  logic                     big_i,
  input  size_e                    size_i,
  input  logic                     nar_valid_i,
  output logic                     nar_ready_o,
  input  logic [LANE_W*LANES-1:0]  nar_data_i,
  output logic                     wide_valid_o,
  input  logic                     wide_ready_i,
  output logic [LANE_W*LANES-1:0]  wide_data_o
);
  localparam int W     = LANE_W * LANES;
  localparam int IDX_W = $clog2(LANES);
  localparam int SH_W  = $clog2(W);

  logic             full_q, full_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     acc_q, acc_d;
  logic             accept, give, last, step_en;
  logic [SH_W-1:0]  shift;
  logic [W-1:0]     mask;

  bwc_lane_map #(.LANE_W(LANE_W), .LANES(LANES)) u_map (
    .big_i   (big_i),
    .size_i  (size_i),
    .idx_i   (idx_q),
    .last_o  (last),
    .shift_o (shift),
    .mask_o  (mask)
  );

  assign give        = full_q && wide_ready_i;
  assign nar_ready_o = cfg_ok_i && (!full_q || wide_ready_i);
  assign accept      = nar_valid_i && nar_ready_o;
  assign step_en     = accept || give;

  always_comb begin
    full_d = full_q && !wide_ready_i;
    idx_d  = idx_q;
    acc_d  = acc_q;
    if (accept) begin
      acc_d = (acc_q & ~(mask << shift)) | ((nar_data_i & mask) << shift);
      if (last) begin
        full_d = 1'b1;
        idx_d  = '0;
      end else begin
        idx_d  = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (step_en) begin
      full_q <= full_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
    end
  end

  assign wide_valid_o = full_q;
  assign wide_data_o  = acc_q;
endmodule

// File: rtl/bus_width_conv.sv
`timescale 1ns/1ps
module bus_width_conv
  import bwc_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     endian_big_i,
  input  logic [1:0]               size_sel_i,
  input  logic                     w2n_wide_valid_i,
  output logic                     w2n_wide_ready_o,
  input  logic [LANE_W*LANES-1:0]  w2n_wide_data_i,
  output logic                     w2n_nar_valid_o,
  input  logic                     w2n_nar_ready_i,
  output logic [LANE_W*LANES-1:0]  w2n_nar_data_o,
  input  logic                     n2w_nar_valid_i,
  output logic                     n2w_nar_ready_o,
  input  logic [LANE_W*LANES-1:0]  n2w_nar_data_i,
  output logic                     n2w_wide_valid_o,
  input  logic                     n2w_wide_ready_i,
  output logic [LANE_W*LANES-1:0]  n2w_wide_data_o
);
  logic  cfg_ok;
  logic  cfg_big;
  size_e cfg_size;

  bwc_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .big_i  (endian_big_i),
    .size_i (size_sel_i),
    .ok_o   (cfg_ok),
    .big_o  (cfg_big),
    .size_o (cfg_size)
  );

  bwc_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ok_i     (cfg_ok),
    .big_i        (cfg_big),
    .size_i       (cfg_size),
    .wide_valid_i (w2n_wide_valid_i),
    .wide_ready_o (w2n_wide_ready_o),
    .wide_data_i  (w2n_wide_data_i),
    .nar_valid_o  (w2n_nar_valid_o),
    .nar_ready_i  (w2n_nar_ready_i),
    .nar_data_o   (w2n_nar_data_o)
  );

  bwc_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ok_i     (cfg_ok),
    .big_i        (cfg_big),
    .size_i       (cfg_size),
    .nar_valid_i  (n2w_nar_valid_i),
    .nar_ready_o  (n2w_nar_ready_o),
    .nar_data_i   (n2w_nar_data_i),
    .wide_valid_o (n2w_wide_valid_o),
    .wide_ready_i (n2w_wide_ready_i),
    .wide_data_o  (n2w_wide_data_o)
  );
endmodule

// File: rtl/bwc_checker.sv
`timescale 1ns/1ps
module bwc_checker
  import bwc_pkg::*;
#(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_ok,
  input logic         cfg_big,
  input logic [1:0]   cfg_size,
  input logic         w2n_wide_valid_i,
  input logic         w2n_wide_ready_o,
  input logic [W-1:0] w2n_wide_data_i,
  input logic         w2n_nar_valid_o,
  input logic         w2n_nar_ready_i,
  input logic [W-1:0] w2n_nar_data_o,
  input logic         n2w_nar_ready_o,
  input logic         n2w_wide_valid_o,
  input logic         n2w_wide_ready_i,
  input logic [W-1:0] n2w_wide_data_o
);
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> cfg_ok && $stable(cfg_big) && $stable(cfg_size));

  p_quiet_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> !w2n_wide_ready_o && !n2w_nar_ready_o
                && !w2n_nar_valid_o && !n2w_wide_valid_o);

  p_long_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_size == SZ_LONG) && w2n_wide_valid_i && w2n_wide_ready_o
    |=> w2n_nar_valid_o && (w2n_nar_data_o == $past(w2n_wide_data_i)));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w2n_nar_valid_o && !w2n_nar_ready_i |-> !w2n_wide_ready_o);

  p_wide_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    n2w_wide_valid_o && !n2w_wide_ready_i
    |=> n2w_wide_valid_o && $stable(n2w_wide_data_o));

  p_nar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    w2n_nar_valid_o && !w2n_nar_ready_i
    |=> w2n_nar_valid_o && $stable(w2n_nar_data_o));

  p_pack_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    n2w_wide_valid_o && !n2w_wide_ready_i |-> !n2w_nar_ready_o);
endmodule

bind bus_width_conv bwc_checker #(.W(LANE_W*LANES)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_ok           (cfg_ok),
  .cfg_big          (cfg_big),
  .cfg_size         (cfg_size),
  .w2n_wide_valid_i (w2n_wide_valid_i),
  .w2n_wide_ready_o (w2n_wide_ready_o),
  .w2n_wide_data_i  (w2n_wide_data_i),
  .w2n_nar_valid_o  (w2n_nar_valid_o),
  .w2n_nar_ready_i  (w2n_nar_ready_i),
  .w2n_nar_data_o   (w2n_nar_data_o),
  .n2w_nar_ready_o  (n2w_nar_ready_o),
  .n2w_wide_valid_o (n2w_wide_valid_o),
  .n2w_wide_ready_i (n2w_wide_ready_i),
  .n2w_wide_data_o  (n2w_wide_data_o)
);

// File: tb/sim_bus_width_conv.sv
`timescale 1ns/1ps
module sim_bus_width_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        endian_big_i = 1'b0;
  logic [1:0]  size_sel_i = 2'b00;
  logic        w2n_wide_valid_i = 1'b0;
  logic        w2n_wide_ready_o;
  logic [35:0] w2n_wide_data_i = '0;
  logic        w2n_nar_valid_o;
  logic        w2n_nar_ready_i = 1'b0;
  logic [35:0] w2n_nar_data_o;
  logic        n2w_nar_valid_i = 1'b0;
  logic        n2w_nar_ready_o;
  logic [35:0] n2w_nar_data_i = '0;
  logic        n2w_wide_valid_o;
  logic        n2w_wide_ready_i = 1'b0;
  logic [35:0] n2w_wide_data_o;

  always #10 clk = ~clk;

  bus_width_conv u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // reference state
  logic [35:0] uq[$];
  logic [35:0] pq[$];
  logic [35:0] ps[$];
  bit m_ok;
  bit m_big;
  int m_n;
  bit w_hs_prev;
  bit n_hs_prev;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                     input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] slot_mask(input int n);
    if (n == 1) return '1;
    return (36'd1 << (36 / n)) - 36'd1;
  endfunction

  function automatic int slot_pos(input int k);
    return m_big ? (m_n - 1 - k) : k;
  endfunction

  function automatic string dtag(input bit to_wide);
    if ((endian_big_i != m_big) || (size_sel_i != 2'b10 && size_sel_i != 2'b11 && m_n == 1))
      return "R1";
    if (m_n == 1) return "R7";
    if (to_wide) return m_big ? "R5/R8" : "R6/R8";
    return m_big ? "R3/R8" : "R4/R8";
  endfunction

  task automatic do_reset(input bit big, input logic [1:0] sz);
    @(negedge clk);
    rst_n = 1'b0;
    w2n_wide_valid_i = 1'b0;
    n2w_nar_valid_i  = 1'b0;
    repeat (3) @(negedge clk);
    chk(!w2n_wide_ready_o && !n2w_nar_ready_o && !w2n_nar_valid_o
        && !n2w_wide_valid_o, "R2", '0, '0);
    endian_big_i = big;
    size_sel_i   = sz;
    rst_n = 1'b1;
    #5;
    // settings not yet sampled: every handshake signal stays low
    chk(!w2n_wide_ready_o && !n2w_nar_ready_o && !w2n_nar_valid_o
        && !n2w_wide_valid_o, "R2", '0, '0);
    uq.delete(); pq.delete(); ps.delete();
    m_big = big;
    m_n   = (sz == 2'b00) ? 4 : (sz == 2'b01) ? 2 : 1;
    m_ok  = 1'b1;
    w_hs_prev = 1'b1;
    n_hs_prev = 1'b1;
  endtask

  task automatic run(input int cycles, input int vrate, input int rrate);
    for (int c = 0; c < cycles; c++) begin
      bit exp_wr, exp_pr, exp_nv, exp_wv, w_hs, n_hs;
      @(negedge clk);
      if (!w2n_wide_valid_i || w_hs_prev) begin
        w2n_wide_valid_i = ($urandom % 100) < vrate;
        w2n_wide_data_i  = {$urandom, $urandom};
      end
      if (!n2w_nar_valid_i || n_hs_prev) begin
        n2w_nar_valid_i = ($urandom % 100) < vrate;
        n2w_nar_data_i  = {$urandom, $urandom};
      end
      w2n_nar_ready_i  = ($urandom % 100) < rrate;
      n2w_wide_ready_i = ($urandom % 100) < rrate;
      if (c == cycles / 2) begin
        // settings inputs move after sampling; order must not change
        endian_big_i = ~endian_big_i;
        size_sel_i   = size_sel_i + 2'd1;
      end
      #5;
      exp_wr = m_ok && (uq.size() == 0 || (uq.size() == 1 && w2n_nar_ready_i));
      exp_nv = uq.size() > 0;
      exp_pr = m_ok && (pq.size() == 0 || n2w_wide_ready_i);
      exp_wv = pq.size() > 0;
      chk(w2n_wide_ready_o == exp_wr, "R9", 36'(w2n_wide_ready_o), 36'(exp_wr));
      chk(w2n_nar_valid_o == exp_nv, "R11", 36'(w2n_nar_valid_o), 36'(exp_nv));
      if (exp_nv) chk(w2n_nar_data_o == uq[0], dtag(1'b0), w2n_nar_data_o, uq[0]);
      chk(n2w_nar_ready_o == exp_pr, "R12", 36'(n2w_nar_ready_o), 36'(exp_pr));
      chk(n2w_wide_valid_o == exp_wv, "R10", 36'(n2w_wide_valid_o), 36'(exp_wv));
      if (exp_wv) chk(n2w_wide_data_o == pq[0], dtag(1'b1), n2w_wide_data_o, pq[0]);
      // advance the model for the coming edge
      if (exp_nv && w2n_nar_ready_i) void'(uq.pop_front());
      w_hs = w2n_wide_valid_i && exp_wr;
      if (w_hs)
        for (int k = 0; k < m_n; k++)
          uq.push_back((w2n_wide_data_i >> (slot_pos(k) * (36 / m_n))) & slot_mask(m_n));
      if (exp_wv && n2w_wide_ready_i) void'(pq.pop_front());
      n_hs = n2w_nar_valid_i && exp_pr;
      if (n_hs) begin
        ps.push_back(n2w_nar_data_i & slot_mask(m_n));
        if (ps.size() == m_n) begin
          logic [35:0] word = '0;
          for (int k = 0; k < m_n; k++)
            word |= ps[k] << (slot_pos(k) * (36 / m_n));
          pq.push_back(word);
          ps.delete();
        end
      end
      w_hs_prev = w_hs;
      n_hs_prev = n_hs;
    end
  endtask

  initial begin
    m_ok = 1'b0; m_big = 1'b0; m_n = 4;
    do_reset(1'b1, 2'b00); run(700, 70, 60);
    do_reset(1'b0, 2'b00); run(700, 80, 40);
    do_reset(1'b1, 2'b01); run(600, 60, 70);
    do_reset(1'b0, 2'b01); run(600, 90, 90);
    do_reset(1'b1, 2'b10); run(500, 70, 50);
    do_reset(1'b0, 2'b11); run(500, 95, 95);
    do_reset(1'b1, 2'b00); run(600, 100, 100);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule